// File: doc/BRIEF.md
# Vertical Blanking Sequencer with Deflection Guard

The block produces the vertical blanking signal for a display deflection controller and protects the picture tube against a failed vertical output stage. A rising edge on the vertical reference input opens a blanking interval. The block then counts line strobes until a programmed number of lines has passed. One line before the last blanked line, it opens a one-line unblanking window. During that window the vertical output stage must return a guard pulse, which reaches this block as a digitised level on `guard_in`.

The interval ends on schedule only if the guard was seen inside the window. If it was not, the block keeps blanking asserted and raises a fault flag. Only the next vertical reference edge starts a new attempt. The fault flag stays set across fields until a later window sees the guard.

All pins are plain control and status levels sampled on the rising clock edge. The block has no data stream, so it has no valid/ready handshake. `line_stb` is a one-cycle pulse per line. `vref` is a level whose rising edge is detected inside the block.

Top module: `vblank_guard`

## Requirements
- R1: When `vref` is first sampled high after being sampled low, `vblank` rises two clock cycles after that sampling edge. The next edge after the sampling edge loads the start, and the edge after that sets `vblank`.
- R2: The interval length is L = max(`start_scan`, 3) lines. `start_scan` is captured when the interval starts, and later changes have no effect on the running interval.
- R3: `vblank` falls at the edge that takes the L-th `line_stb` counted from the interval start, provided the guard was seen in that interval.
- R4: `unblank` is high for exactly one line. It opens at the edge taking strobe L-2 and closes at the edge taking strobe L-1. It is only ever high while `vblank` is high.
- R5: `guard_in` counts only on clock edges where `unblank` is high. A high level at any other time has no effect on release or on the fault flag.
- R6: If the guard was not seen in the window, `vblank` stays high past the L-th strobe. It stays high through any number of further strobes until the next `vref` rising edge.
- R7: `guard_fault` is updated at the edge that closes the window: it is set if the guard was absent and cleared if it was present. At all other times it holds its value, including across a restart.
- R8: A `vref` rising edge restarts the sequence from any state: idle, mid-interval or held. The line count starts again from zero, and the guard record is cleared.
- R9: While idle, `line_stb` and `guard_in` change none of the outputs.
- R10: After reset, `vblank`, `unblank` and `guard_fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| vref | input | 1 | Vertical reference level; a rising edge starts an interval |
| line_stb | input | 1 | One-cycle pulse per line |
| start_scan | input | 6 | Number of blanked lines, minimum 3 |
| guard_in | input | 1 | Digitised guard-detect level from the vertical output stage |
| vblank | output | 1 | Vertical blanking active |
| unblank | output | 1 | One-line guard sensing window |
| guard_fault | output | 1 | Last closed window saw no guard |

## Verification
The hardest state to reach is a held interval that is interrupted by a restart. The stimulus gets there by letting a field run with no guard, or with the guard high only outside the window. A new `vref` edge then arrives while `vblank` is still held, and the bench checks that the line count starts over and that the fault flag survives the restart until the next window closes. The sweep covers every `start_scan` value, including those below the minimum. For each value it runs the three guard patterns in sequence, so every transition among idle, held and faulted state is reached. A separate case restarts an interval in mid-count.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

  // Sequencer state: scanning (idle), blanking interval running, blanking held
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_BLANK = 2'd1,
    ST_HOLD  = 2'd2
  } vbg_state_e;

  // Shortest interval that leaves room for the window and one line after it
  localparam int unsigned VBG_MIN_LINES  = 3;
  // Window sits this many lines before the programmed end
  localparam int unsigned VBG_WIN_BEFORE = 2;

endpackage

// File: rtl/vbg_ref_delay.sv
// Detects the rising edge of the reference level and delays the resulting
// start pulse so that blanking rises DLY cycles after the sampling edge.
module vbg_ref_delay #(
  parameter int unsigned DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vref,
  output logic start
);

  localparam int unsigned STAGES = (DLY > 1) ? DLY - 1 : 1;

  logic ref_s1, ref_s2;
  logic rise;
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s1 <= 1'b0;
      ref_s2 <= 1'b0;
    end else begin
      ref_s1 <= vref;
      ref_s2 <= ref_s1;
    end
  end

  assign rise = ref_s1 & ~ref_s2;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= rise;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], rise};
      end
    end
  endgenerate

  assign start = pipe_q[STAGES-1];

endmodule

// File: rtl/vbg_line_seq.sv
// Captures the interval length at start, counts lines while the interval
// runs, and decodes the sensing window and the final line.
module vbg_line_seq
  import vbg_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             line_stb,
  input  logic [CNT_W-1:0] setting,
  output logic             win,
  output logic             win_close,
  output logic             last_line
);

  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(VBG_MIN_LINES);
  localparam logic [CNT_W-1:0] WIN_B = CNT_W'(VBG_WIN_BEFORE);

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_eff;
  logic             step;

  assign len_eff = (setting < MIN_V) ? MIN_V : setting;
  assign step    = active & line_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= MIN_V;
      cnt_q <= '0;
    end else if (start) begin
      len_q <= len_eff;
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign win       = active && (cnt_q == len_q - WIN_B);
  assign win_close = win & line_stb;
  assign last_line = step && (cnt_q == len_q - 1'b1);

endmodule

// File: rtl/vbg_guard_mon.sv
// Records whether the guard was present during the window and keeps the
// fault flag, which changes only when a window closes.
module vbg_guard_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic win,
  input  logic win_close,
  input  logic guard_in,
  output logic guard_ok,
  output logic fault
);

  logic seen_q;
  logic fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (start) begin
      seen_q <= 1'b0;
    end else if (win && guard_in) begin
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (win_close && !start) begin
      fault_q <= ~(seen_q | guard_in);
    end
  end

  assign guard_ok = seen_q;
  assign fault    = fault_q;

endmodule

// File: rtl/vblank_guard.sv
// Vertical blanking sequencer with guard-gated release.
module vblank_guard
  import vbg_pkg::*;
#(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned START_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vref,
  input  logic             line_stb,
  input  logic [CNT_W-1:0] start_scan,
  input  logic             guard_in,
  output logic             vblank,
  output logic             unblank,
  output logic             guard_fault
);

  vbg_state_e state_q, state_d;
  logic start;
  logic active;
  logic win, win_close, last_line;
  logic guard_ok;

  vbg_ref_delay #(.DLY(START_DLY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .vref  (vref),
    .start (start)
  );

  assign active = (state_q == ST_BLANK);

  vbg_line_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .active    (active),
    .line_stb  (line_stb),
    .setting   (start_scan),
    .win       (win),
    .win_close (win_close),
    .last_line (last_line)
  );

  vbg_guard_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .win       (win),
    .win_close (win_close),
    .guard_in  (guard_in),
    .guard_ok  (guard_ok),
    .fault     (guard_fault)
  );

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_BLANK;
    end else begin
      case (state_q)
        ST_BLANK: if (last_line) state_d = guard_ok ? ST_SCAN : ST_HOLD;
        ST_HOLD:  state_d = ST_HOLD;
        default:  state_d = ST_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SCAN;
    else        state_q <= state_d;
  end

  assign vblank  = (state_q != ST_SCAN);
  assign unblank = win;

endmodule

// File: rtl/vblank_guard_chk.sv
module vblank_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic vref,
  input logic line_stb,
  input logic guard_in,
  input logic vblank,
  input logic unblank,
  input logic guard_fault
);

  // R1: reference edge sampled at one edge gives vblank visible three samples later
  p_start_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vref && !$past(vref)) |-> ##3 vblank);

  // R4: window only inside blanking
  p_win_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unblank |-> vblank);

  // R4: window opens only on a line strobe
  p_win_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unblank) |-> $past(line_stb));

  // R7: fault holds unless a window was open on the previous edge
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(unblank) |-> $stable(guard_fault));

  // R3: release only on a strobe and never with a pending fault
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> ($past(line_stb) && !guard_fault));

  // R5: fault rises only when a window closed without guard at that edge
  p_fault_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_fault) |-> ($past(unblank) && $past(line_stb) && !$past(guard_in)));

endmodule

bind vblank_guard vblank_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vref        (vref),
  .line_stb    (line_stb),
  .guard_in    (guard_in),
  .vblank      (vblank),
  .unblank     (unblank),
  .guard_fault (guard_fault)
);

// File: tb/sim_vblank_guard.sv
`timescale 1ns/1ps
module sim_vblank_guard;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vref = 1'b0;
  logic       line_stb = 1'b0;
  logic [5:0] start_scan = 6'd0;
  logic       guard_in = 1'b0;
  logic       vblank, unblank, guard_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit prev_hold = 1'b0;
  bit prev_fault = 1'b0;

  always #2.5 clk = ~clk;

  vblank_guard u0 (
    .clk(clk), .rst_n(rst_n), .vref(vref), .line_stb(line_stb),
    .start_scan(start_scan), .guard_in(guard_in),
    .vblank(vblank), .unblank(unblank), .guard_fault(guard_fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Pulse vref and check the start timing (R1) and restart effects (R8)
  task automatic start_field(input int n);
    start_scan = 6'(n);
    vref = 1'b1;
    tick();                                  // after sampling edge E0
    chk("R1 E0", vblank, prev_hold);
    tick();                                  // after E1
    chk("R1 E1", vblank, prev_hold);
    tick();                                  // after E2
    chk("R1 E2 vblank", vblank, 1);
    chk("R8 restart keeps fault", guard_fault, prev_fault);
    chk("R8 window closed at start", unblank, 0);
    start_scan = 6'(n) ^ 6'h15;              // R2: late change ignored
    vref = 1'b0;
  endtask

  // mode 0: no guard, 1: guard in window, 2: guard only outside window
  // stop < L runs a partial interval
  task automatic run_lines(input int n, input int mode, input int stop);
    int len;
    len = (n < 3) ? 3 : n;
    for (int k = 0; k < stop; k++) begin
      guard_in = (mode == 1) ? (k == len - 2) : (mode == 2) ? (k != len - 2) : 1'b0;
      for (int c = 0; c < 3; c++) begin
        chk("R4 window position", unblank, (k == len - 2) ? 1 : 0);
        chk("R6 blank during count", vblank, 1);
        if (k == len - 1)
          chk("R7 fault at window close", guard_fault, (mode == 1) ? 0 : 1);
        tick();
      end
      line_stb = 1'b1;
      tick();
      line_stb = 1'b0;
    end
    guard_in = 1'b0;
  endtask

  task automatic run_field(input int n, input int mode);
    int len;
    len = (n < 3) ? 3 : n;
    start_field(n);
    run_lines(n, mode, len);
    chk(mode == 1 ? "R3 release" : "R6 held", vblank, (mode == 1) ? 0 : 1);
    chk("R4 window closed at end", unblank, 0);
    // extra strobes and guard after the interval
    guard_in = 1'b1;
    for (int e = 0; e < 2; e++) begin
      line_stb = 1'b1; tick(); line_stb = 1'b0; tick();
      chk(mode == 1 ? "R9 idle strobe" : "R6 hold past strobes", vblank, (mode == 1) ? 0 : 1);
      chk("R5 guard outside window", guard_fault, (mode == 1) ? 0 : 1);
      chk("R9 no window", unblank, 0);
    end
    guard_in = 1'b0;
    prev_hold  = (mode != 1);
    prev_fault = (mode != 1);
  endtask

  initial begin
    repeat (3) tick();
    chk("R10 vblank", vblank, 0);
    chk("R10 unblank", unblank, 0);
    chk("R10 fault", guard_fault, 0);
    rst_n = 1'b1;
    tick();

    // idle with strobes and guard: nothing moves (R9)
    guard_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      line_stb = 1'b1; tick(); line_stb = 1'b0; tick();
      chk("R9 idle vblank", vblank, 0);
      chk("R9 idle fault", guard_fault, 0);
    end
    guard_in = 1'b0;

    // full sweep of the setting with all guard patterns (R2..R7)
    for (int n = 0; n < 64; n++) begin
      for (int m = 0; m < 3; m++) begin
        run_field(n, m);
        repeat (2) tick();
      end
    end

    // R8: mid-interval restart, count begins again under the new length
    run_field(5, 1);
    start_field(20);
    run_lines(20, 1, 7);
    prev_hold = 1'b1;
    run_field(6, 1);
    chk("R8 restart release", vblank, 0);

    // R8: restart of a held interval with a fault pending
    run_field(4, 0);
    run_field(9, 1);
    chk("R8 held restart fault cleared", guard_fault, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule